// File: doc/BRIEF.md
# MII Nibble Transmitter

This block sits between a MAC's byte-wide transmit stream and the 4-bit transmit side of a Media Independent Interface. It runs entirely on the transmit clock that the PHY supplies. Each nibble takes exactly one clock cycle, and no timing depends on the clock frequency. The same logic therefore serves a 25 MHz clock at 100 Mb/s and a 2.5 MHz clock at 10 Mb/s. When a frame starts, the block sends a fixed eight-byte header (seven 0x55 bytes and the 0xD5 delimiter). It then sends the MAC's bytes as nibble pairs and ends the frame with a 32-bit frame check sequence that it computes itself.

The MAC offers bytes with `in_valid`, marks the first byte with `in_sof` and the last byte with `in_eof`, and watches `in_ready` to know when a byte has been taken. The error output of the interface is never used. A frame that cannot be completed correctly still ends normally, but its check sequence is sent bitwise complemented, so the receiver discards it. Two things mark a frame as damaged: an explicit error request on `in_abort`, and the byte source failing to supply a byte when one is needed (an underrun).

Top module: `mii_nibble_tx`

## Requirements
- R1: After reset `mii_tx_en` is 0, `mii_txd` is 0, `mii_tx_er` is 0 and `in_ready` is 1.
- R2: `mii_tx_er` is 0 in every cycle.
- R3: A byte with `in_valid` and `in_sof` high, presented while idle, is accepted. On the next clock `mii_tx_en` rises, and the first 16 nibbles are fifteen 0x5 nibbles followed by one 0xD nibble.
- R4: Each data byte occupies two consecutive cycles: bits 3:0 in the first cycle, then bits 7:4. Bytes go out in the order they were accepted.
- R5: After the last data nibble come 8 FCS nibbles. The FCS is F = complement of the CRC-32 (reflected polynomial 0xEDB88320, register preset to all ones, bits fed LSB first) over the data bytes. Nibble k carries F bits 4k+3:4k, for k = 0..7.
- R6: `mii_tx_en` is high without a gap from the first header nibble through the last FCS nibble (16 + 2N + 8 cycles for N bytes), then drops for at least one cycle. `mii_txd` is 0 whenever `mii_tx_en` is 0.
- R7: `in_abort` high in any cycle from the one after start-of-frame acceptance through the last data nibble lets the frame run to its last byte and sends the complement of F in place of F. `in_abort` while idle has no effect on the next frame.
- R8: `in_ready` is high in the second-nibble cycle of each byte not marked last. If `in_valid` is low in that cycle, the data ends after the current byte and the FCS follows at once, sent as the complement of F over the bytes actually sent.
- R9: `in_ready` is 1 only while idle or in the second-nibble cycle of a byte not marked last. While idle, a byte offered without `in_sof` is dropped and starts nothing.
- R10: A frame's error state does not carry over: the frame after a damaged one gets a correct FCS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mii_tx_clk | input | 1 | PHY-supplied transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Byte from the MAC |
| in_valid | input | 1 | `in_data` is offered |
| in_sof | input | 1 | Offered byte is the first of a frame |
| in_eof | input | 1 | Offered byte is the last of a frame |
| in_abort | input | 1 | Request to mark the current frame as bad |
| in_ready | output | 1 | Offered byte is taken at this clock edge |
| mii_txd | output | 4 | Transmit nibble |
| mii_tx_en | output | 1 | Transmit enable |
| mii_tx_er | output | 1 | Transmit error, held at 0 |

## Verification
The hardest case to reach from the ports is an underrun. It is not an input: it happens only when the source stays silent in the single cycle in which the block asks for the next byte. The bench reaches it with a driver that follows `in_ready` cycle by cycle and simply stops offering bytes after a chosen count, without raising `in_eof`. It then checks that the frame is cut after that byte and that the complemented FCS covers exactly the bytes sent. The bench also checks the abort window at its edges: an abort pulsed while idle, and one pulsed on the first accepted data byte.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_FCS  = 2'd3
  } tx_state_e;

  localparam int FCS_BITS   = 32;
  localparam int FCS_NIB    = FCS_BITS / 4;
  localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
  localparam logic [3:0]  HDR_FILL   = 4'h5;
  localparam logic [3:0]  HDR_DELIM  = 4'hD;

  // Reflected CRC-32 update with one byte, least-significant bit first.
  function automatic logic [31:0] crc_add_byte(input logic [31:0] crc_in,
                                               input logic [7:0]  b);
    logic [31:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY_R;
      else             c = c >> 1;
    end
    return c;
  endfunction

  // Nibble k of the check sequence; a bad frame sends the raw register.
  function automatic logic [3:0] fcs_nibble(input logic [31:0] crc_reg,
                                            input logic        bad,
                                            input logic [2:0]  k);
    logic [31:0] v;
    v = bad ? crc_reg : ~crc_reg;
    return v[{k, 2'b00} +: 4];
  endfunction

endpackage

// File: rtl/mii_tx_ctrl.sv
module mii_tx_ctrl
  import mii_tx_pkg::*;
#(
  parameter int HDR_NIB = 16,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_abort,
  output logic             in_ready,
  output tx_state_e        st_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hi_q,
  output logic [7:0]       cur_q,
  output logic             bad_q,
  output logic             ev_start,
  output logic             ev_byte_done
);

  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_NIB - 1);
  localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_NIB - 1);

  logic last_q;
  logic at_hi;
  logic ev_take;
  logic ev_underrun;
  logic ev_abort;
  logic hdr_done;
  logic fcs_done;

  always_comb begin
    at_hi        = (st_q == ST_DATA) && hi_q;
    ev_start     = (st_q == ST_IDLE) && in_valid && in_sof;
    ev_take      = at_hi && !last_q && in_valid;
    ev_underrun  = at_hi && !last_q && !in_valid;
    ev_byte_done = at_hi;
    ev_abort     = in_abort && ((st_q == ST_HDR) || (st_q == ST_DATA));
    hdr_done     = (st_q == ST_HDR) && (cnt_q == HDR_LAST);
    fcs_done     = (st_q == ST_FCS) && (cnt_q == FCS_LAST);
    in_ready     = (st_q == ST_IDLE) || (at_hi && !last_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hi_q   <= 1'b0;
      cur_q  <= '0;
      last_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      if (ev_abort) bad_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (ev_start) begin
            st_q   <= ST_HDR;
            cnt_q  <= '0;
            cur_q  <= in_data;
            last_q <= in_eof;
            bad_q  <= 1'b0;
          end
        end
        ST_HDR: begin
          if (hdr_done) begin
            st_q  <= ST_DATA;
            cnt_q <= '0;
            hi_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (!hi_q) begin
            hi_q <= 1'b1;
          end else if (ev_take) begin
            cur_q  <= in_data;
            last_q <= in_eof;
            hi_q   <= 1'b0;
          end else begin
            st_q  <= ST_FCS;
            cnt_q <= '0;
            hi_q  <= 1'b0;
            if (ev_underrun) bad_q <= 1'b1;
          end
        end
        default: begin
          if (fcs_done) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  // R3: an accepted start byte opens the header at its first nibble.
  p_start_opens_hdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (st_q == ST_HDR) && (cnt_q == '0));

  // R9: the source is asked for a byte only in the allowed cycles.
  p_ready_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> ((st_q == ST_IDLE) || ((st_q == ST_DATA) && hi_q && !last_q)));

  // R4: the low nibble is always followed by the high nibble of the same byte.
  p_nibble_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DATA) && !hi_q) |=> ((st_q == ST_DATA) && hi_q && $stable(cur_q)));

  // R8: a missing byte ends the data and marks the frame bad.
  p_underrun_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underrun |=> ((st_q == ST_FCS) && bad_q && (cnt_q == '0)));

  // R6: the last byte leads straight into the check sequence.
  p_last_to_fcs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_hi && last_q) |=> ((st_q == ST_FCS) && (cnt_q == '0)));

  // R6: the check sequence ends the frame.
  p_fcs_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_done |=> (st_q == ST_IDLE));

  // R7: an abort inside the frame sticks until the frame ends.
  p_abort_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> bad_q);

  // R10: a new frame starts clean.
  p_fresh_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !bad_q);

endmodule

// File: rtl/mii_tx_crc.sv
module mii_tx_crc
  import mii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= CRC_PRESET;
    else if (clr) crc_q <= CRC_PRESET;
    else if (upd) crc_q <= crc_add_byte(crc_q, din);
  end

  // R5: the register starts each frame from the preset.
  p_crc_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == CRC_PRESET));

  // R5: only a finished byte moves the register.
  p_crc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(crc_q));

endmodule

// File: rtl/mii_tx_out.sv
module mii_tx_out
  import mii_tx_pkg::*;
#(
  parameter int HDR_NIB = 16,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tx_state_e        st,
  input  logic [CNT_W-1:0] cnt,
  input  logic             hi,
  input  logic [7:0]       cur,
  input  logic [31:0]      crc,
  input  logic             bad,
  output logic [3:0]       txd,
  output logic             tx_en
);

  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_NIB - 1);

  always_comb begin
    tx_en = (st != ST_IDLE);
    case (st)
      ST_HDR:  txd = (cnt == HDR_LAST) ? HDR_DELIM : HDR_FILL;
      ST_DATA: txd = hi ? cur[7:4] : cur[3:0];
      ST_FCS:  txd = fcs_nibble(crc, bad, cnt[2:0]);
      default: txd = 4'h0;
    endcase
  end

  // R6: the bus is quiet whenever enable is low.
  p_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (txd == 4'h0));

endmodule

// File: rtl/mii_nibble_tx.sv
module mii_nibble_tx
  import mii_tx_pkg::*;
#(
  parameter int HDR_BYTES = 8
) (
  input  logic       mii_tx_clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       in_abort,
  output logic       in_ready,
  output logic [3:0] mii_txd,
  output logic       mii_tx_en,
  output logic       mii_tx_er
);

  localparam int HDR_NIB = 2 * HDR_BYTES;
  localparam int MAX_NIB = (HDR_NIB > FCS_NIB) ? HDR_NIB : FCS_NIB;
  localparam int CNT_W   = $clog2(MAX_NIB);

  tx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             hi;
  logic [7:0]       cur;
  logic             bad;
  logic             ev_start;
  logic             ev_byte_done;
  logic [31:0]      crc;

  mii_tx_ctrl #(.HDR_NIB(HDR_NIB), .CNT_W(CNT_W)) u_ctrl (
    .clk          (mii_tx_clk),
    .rst_n        (rst_n),
    .in_data      (in_data),
    .in_valid     (in_valid),
    .in_sof       (in_sof),
    .in_eof       (in_eof),
    .in_abort     (in_abort),
    .in_ready     (in_ready),
    .st_q         (st),
    .cnt_q        (cnt),
    .hi_q         (hi),
    .cur_q        (cur),
    .bad_q        (bad),
    .ev_start     (ev_start),
    .ev_byte_done (ev_byte_done)
  );

  mii_tx_crc u_crc (
    .clk   (mii_tx_clk),
    .rst_n (rst_n),
    .clr   (ev_start),
    .upd   (ev_byte_done),
    .din   (cur),
    .crc_q (crc)
  );

  mii_tx_out #(.HDR_NIB(HDR_NIB), .CNT_W(CNT_W)) u_out (
    .clk   (mii_tx_clk),
    .rst_n (rst_n),
    .st    (st),
    .cnt   (cnt),
    .hi    (hi),
    .cur   (cur),
    .crc   (crc),
    .bad   (bad),
    .txd   (mii_txd),
    .tx_en (mii_tx_en)
  );

  assign mii_tx_er = 1'b0;

  // R2: the error line never rises.
  p_er_low_r2: assert property (@(posedge mii_tx_clk) disable iff (!rst_n)
    !mii_tx_er);

endmodule

// File: tb/mii_nibble_tx_tb_top.sv
module mii_nibble_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       in_abort = 1'b0;
  logic       in_ready;
  logic [3:0] mii_txd;
  logic       mii_tx_en;
  logic       mii_tx_er;

  always #10 clk = ~clk;

  mii_nibble_tx dut_i (
    .mii_tx_clk (clk),
    .rst_n      (rst_n),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .in_abort   (in_abort),
    .in_ready   (in_ready),
    .mii_txd    (mii_txd),
    .mii_tx_en  (mii_tx_en),
    .mii_tx_er  (mii_tx_er)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit wd_hit  = 0;

  logic [7:0] fb [0:63];
  logic [3:0] cap [0:255];
  logic [3:0] expn [0:255];
  int  cap_n = 0;
  int  rdy_cnt = 0;
  int  first_en_cyc = 0;
  int  er_seen = 0;
  int  quiet_bad = 0;
  int  acc_cyc = 0;
  bit  en_prev = 0;
  bit  frame_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1;
      n_fail++;
      $display("FAIL R6 watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mii_tx_er !== 1'b0) er_seen++;
      if (!mii_tx_en && mii_txd !== 4'h0) quiet_bad++;
      if (mii_tx_en) begin
        if (!en_prev) begin
          cap_n = 0;
          rdy_cnt = 0;
          first_en_cyc = cyc;
        end
        if (cap_n < 256) cap[cap_n] = mii_txd;
        cap_n++;
        if (in_ready) rdy_cnt++;
      end else if (en_prev) begin
        frame_done = 1;
      end
      en_prev = mii_tx_en;
    end
  end

  // Independent reference: MSB-first register fed LSB-first, result reflected.
  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c;
    logic [31:0] r;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic fbit;
        fbit = c[31] ^ fb[i][j];
        c = c << 1;
        if (fbit) c = c ^ 32'h04C1_1DB7;
      end
    end
    for (int j = 0; j < 32; j++) r[j] = c[31-j];
    return ~r;
  endfunction

  function automatic int build_exp(input int n, input bit bad);
    logic [31:0] f;
    int k;
    k = 0;
    for (int i = 0; i < 15; i++) begin expn[k] = 4'h5; k++; end
    expn[k] = 4'hD; k++;
    for (int i = 0; i < n; i++) begin
      expn[k] = fb[i][3:0]; k++;
      expn[k] = fb[i][7:4]; k++;
    end
    f = ref_fcs(n);
    if (bad) f = ~f;
    for (int i = 0; i < 8; i++) begin expn[k] = f[4*i +: 4]; k++; end
    return k;
  endfunction

  // Drive bytes 0..sent-1; n is the frame length (eof on byte n-1).
  task automatic send_frame(input int n, input int sent, input int abort_idx);
    int i;
    int guard;
    i = 0;
    guard = 0;
    frame_done = 0;
    while (i < sent && guard < 2000) begin
      @(negedge clk);
      guard++;
      in_valid = 1'b1;
      in_data  = fb[i];
      in_sof   = (i == 0);
      in_eof   = (i == n - 1);
      in_abort = 1'b0;
      if (in_ready) begin
        if (i == abort_idx) in_abort = 1'b1;
        if (i == 0) acc_cyc = cyc;
        i++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_abort = 1'b0;
    guard = 0;
    while (!frame_done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(frame_done, "R6", "frame end seen", frame_done, 1);
  endtask

  task automatic check_frame(input string req, input int n, input bit bad,
                             input int exp_rdy);
    int len;
    int bad_hdr;
    int bad_dat;
    int bad_fcs;
    len = build_exp(n, bad);
    chk(cap_n == len, "R6", "enable length", cap_n, len);
    chk(first_en_cyc == acc_cyc + 1, "R3", "start latency", first_en_cyc, acc_cyc + 1);
    bad_hdr = 0; bad_dat = 0; bad_fcs = 0;
    for (int i = 0; i < len && i < cap_n; i++) begin
      if (cap[i] !== expn[i]) begin
        if (i < 16) bad_hdr++;
        else if (i < 16 + 2 * n) bad_dat++;
        else bad_fcs++;
      end
    end
    chk(bad_hdr == 0, "R3", "header nibbles wrong", bad_hdr, 0);
    chk(bad_dat == 0, "R4", "data nibbles wrong", bad_dat, 0);
    chk(bad_fcs == 0, req, "fcs nibbles wrong", bad_fcs, 0);
    chk(rdy_cnt == exp_rdy, "R9", "ready cycles in frame", rdy_cnt, exp_rdy);
  endtask

  task automatic t_reset_r1;
    @(negedge clk);
    chk(mii_tx_en == 1'b0, "R1", "tx_en after reset", mii_tx_en, 0);
    chk(mii_txd == 4'h0, "R1", "txd after reset", mii_txd, 0);
    chk(mii_tx_er == 1'b0, "R1", "tx_er after reset", mii_tx_er, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_idle_drop_r9;
    int en_hi;
    en_hi = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_data = 8'hA7;
      if (mii_tx_en) en_hi++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (mii_tx_en) en_hi++;
    @(negedge clk);
    if (mii_tx_en) en_hi++;
    chk(en_hi == 0, "R9", "byte without sof started a frame", en_hi, 0);
  endtask

  task automatic t_known_vector_r5;
    string s;
    s = "123456789";
    for (int i = 0; i < 9; i++) fb[i] = s[i];
    chk(ref_fcs(9) == 32'hCBF4_3926, "R5", "reference check value", ref_fcs(9), 32'hCBF43926);
    send_frame(9, 9, -1);
    check_frame("R5", 9, 1'b0, 8);
    chk({cap[16+18+7], cap[16+18+6], cap[16+18+5], cap[16+18+4],
         cap[16+18+3], cap[16+18+2], cap[16+18+1], cap[16+18]} == 32'hCBF4_3926,
        "R5", "known fcs on wire",
        {cap[41], cap[40], cap[39], cap[38], cap[37], cap[36], cap[35], cap[34]},
        32'hCBF43926);
  endtask

  task automatic t_patterns_r4;
    for (int i = 0; i < 20; i++) fb[i] = 8'(i * 37 + 11);
    send_frame(20, 20, -1);
    check_frame("R5", 20, 1'b0, 19);
    for (int i = 0; i < 6; i++) fb[i] = (i % 2 == 0) ? 8'h0F : 8'hF0;
    send_frame(6, 6, -1);
    check_frame("R4", 6, 1'b0, 5);
  endtask

  task automatic t_single_byte_r6;
    fb[0] = 8'h3C;
    send_frame(1, 1, -1);
    check_frame("R6", 1, 1'b0, 0);
  endtask

  task automatic t_abort_r7;
    for (int i = 0; i < 8; i++) fb[i] = 8'(8'hC0 + i);
    send_frame(8, 8, 3);
    check_frame("R7", 8, 1'b1, 7);
    send_frame(8, 8, 1);
    check_frame("R7", 8, 1'b1, 7);
  endtask

  task automatic t_abort_idle_r7;
    @(negedge clk);
    in_abort = 1'b1;
    @(negedge clk);
    in_abort = 1'b0;
    for (int i = 0; i < 5; i++) fb[i] = 8'(8'h91 ^ i);
    send_frame(5, 5, -1);
    check_frame("R7", 5, 1'b0, 4);
  endtask

  task automatic t_underrun_r8;
    for (int i = 0; i < 12; i++) fb[i] = 8'(8'h5A + 3 * i);
    send_frame(12, 4, -1);
    check_frame("R8", 4, 1'b1, 4);
  endtask

  task automatic t_after_error_r10;
    for (int i = 0; i < 7; i++) fb[i] = 8'(8'hE1 - 5 * i);
    send_frame(7, 7, -1);
    check_frame("R10", 7, 1'b0, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_idle_drop_r9();
    t_known_vector_r5();
    t_patterns_r4();
    t_single_byte_r6();
    t_abort_r7();
    t_after_error_r10();
    t_abort_idle_r7();
    t_underrun_r8();
    t_after_error_r10();
    chk(er_seen == 0, "R2", "tx_er high cycles", er_seen, 0);
    chk(quiet_bad == 0, "R6", "txd nonzero while idle", quiet_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule